// File: doc/BRIEF.md
# Packet Controller FIFO Pair with Delayed Status

This block sits between a processor bus and the serial side of a packet link controller. It holds two byte queues. The processor fills the transmit queue by writing a data address, and the serial side drains it one byte per pop strobe. The serial side fills the receive queue, one byte per push strobe. Each received byte carries a two-bit tag that gives its place in a frame and the outcome of the frame check. The processor drains the receive queue by reading a data address.

A read-only status byte reports three things: the tag of the oldest received byte, a coarse four-state level for the receive queue and a coarse four-state level for the transmit queue. The level fields change only after a set number of serial-clock falling edges have passed since the last accepted access to that queue. The serial side signals each falling edge with a one-cycle enable pulse. A mode input picks a wait of two edges or four edges. Bytes keep their bit positions across the block, so the bit that the serial side sends or receives first is bit 0 on the bus.

Top module: `frame_fifo_port`

## Requirements
- R1: After reset the status byte (address 0) reads 0x08, `err_o` is 0 and `tx_valid_o` is 0.
- R2: A bus read at address 1 returns the oldest received byte with its bits in their original positions (serial bit 0 on bus bit 0) and removes that byte. Bytes come out in the order they were pushed.
- R3: A bus write at address 2 queues the bus byte for transmission. `tx_byte_o` shows the oldest queued byte and `tx_pop_i` removes it, in write order.
- R4: Status bits 7:6 hold the tag of the oldest received byte: 00 middle byte, 01 first byte, 10 last byte with a good check, 11 last byte with a bad check. They read 00 while the receive queue is empty.
- R5: Status bits 5:4 give the receive level: 00 empty, 01 from 1 to 14 bytes, 11 from 15 to 18 bytes, 10 full (19 bytes).
- R6: Status bits 3:2 give the transmit level: 10 empty, 11 from 1 to 4 bytes, 01 from 5 to 18 bytes, 00 full (19 bytes).
- R7: Status bits 1:0 always read 0.
- R8: With `clk_mode_i` other than 2'b10, a level field takes its new value on the second serial-edge pulse after the last accepted access to its queue, and not before that pulse.
- R9: With `clk_mode_i` equal to 2'b10, the wait is four serial-edge pulses.
- R10: Another accepted access to a queue before its wait has ended starts the wait again from the beginning.
- R11: Each queue holds 19 bytes. A push to a full queue is dropped and sets the sticky `err_o`, which stays set until reset.
- R12: A pop from an empty queue leaves the pointers unchanged, sets `err_o`, and a receive read then returns the last byte that was removed (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus side and the serial side |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 2 | Register select: 0 status, 1 receive data, 2 transmit data |
| bus_rd_i | input | 1 | Read strobe; at address 1 it pops the receive queue |
| bus_wr_i | input | 1 | Write strobe; at address 2 it pushes the transmit queue |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected address |
| ser_edge_i | input | 1 | One-cycle pulse for each serial-clock falling edge |
| clk_mode_i | input | 2 | 2'b10 selects the four-edge status wait; other values select two edges |
| rx_push_i | input | 1 | Serial side writes one received byte |
| rx_byte_i | input | 8 | Received byte |
| rx_tag_i | input | 2 | Frame position and check tag of the received byte |
| tx_pop_i | input | 1 | Serial side takes the oldest transmit byte |
| tx_byte_o | output | 8 | Oldest transmit byte |
| tx_valid_o | output | 1 | Transmit queue holds at least one byte |
| err_o | output | 1 | Sticky flag for a dropped push or an empty pop |

## Verification
The assertions assume that every strobe lasts one cycle and is sampled on a rising clock edge, and that `clk_mode_i` stays constant while a wait is running. The bench drives each strobe for one cycle from the falling clock edge. It gives each access and each serial-edge pulse a cycle of its own, so that an edge count never shares a cycle with an access to the same queue. It changes the mode only between phases, once no wait is pending. Overflow and underflow are driven on purpose so that the paths for dropped pushes and empty pops run.

// File: rtl/frame_fifo_pkg.sv
package frame_fifo_pkg;

    typedef enum logic [1:0] {
        TAG_MIDDLE   = 2'b00,
        TAG_FIRST    = 2'b01,
        TAG_LAST_OK  = 2'b10,
        TAG_LAST_BAD = 2'b11
    } frame_tag_e;

    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_RXDATA = 2'd1;
    localparam logic [1:0] ADDR_TXDATA = 2'd2;

    localparam logic [1:0] MODE_FAST_INT = 2'b10;

    // receive level: empty, low, high, full
    function automatic logic [1:0] rx_level_code(input int n, input int depth, input int hi);
        if (n == 0)          return 2'b00;
        else if (n >= depth) return 2'b10;
        else if (n >= hi)    return 2'b11;
        else                 return 2'b01;
    endfunction

    // transmit level: full, high, empty, low
    function automatic logic [1:0] tx_level_code(input int n, input int depth, input int hi);
        if (n >= depth)      return 2'b00;
        else if (n == 0)     return 2'b10;
        else if (n >= hi)    return 2'b01;
        else                 return 2'b11;
    endfunction

endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 19,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] head_o,
    output logic [CW-1:0]    count_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             push_ok_o,
    output logic             pop_ok_o
);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } q_state_t;

    q_state_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full_o    = (st_q.cnt == CW'(DEPTH));
    assign empty_o   = (st_q.cnt == '0);
    assign push_ok_o = push_i && !full_o;
    assign pop_ok_o  = pop_i && !empty_o;
    assign count_o   = st_q.cnt;
    assign head_o    = mem_q[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (push_ok_o) st_d.wr = bump(st_q.wr);
        if (pop_ok_o)  st_d.rd = bump(st_q.rd);
        case ({push_ok_o, pop_ok_o})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok_o) mem_q[st_q.wr] <= wdata_i;
    end

    p_depth_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

    p_drop_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> $stable(count_o));

    p_hold_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> ($stable(count_o) && $stable(st_q.rd)));

endmodule

// File: rtl/level_tracker.sv
module level_tracker #(
    parameter int DEPTH       = 19,
    parameter int HI_TH       = 15,
    parameter bit IS_RX       = 1'b1,
    parameter int SHORT_EDGES = 2,
    parameter int LONG_EDGES  = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int EW   = $clog2(LONG_EDGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          access_i,
    input  logic          ser_edge_i,
    input  logic          long_wait_i,
    input  logic [CW-1:0] count_i,
    output logic [1:0]    code_o
);
    import frame_fifo_pkg::*;

    localparam logic [1:0] RST_CODE = IS_RX ? rx_level_code(0, DEPTH, HI_TH)
                                            : tx_level_code(0, DEPTH, HI_TH);

    typedef struct packed {
        logic          pend;
        logic [EW-1:0] left;
        logic [1:0]    code;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic [1:0] code_now;

    generate
        if (IS_RX) begin : g_rx_enc
            always_comb code_now = rx_level_code(int'(count_i), DEPTH, HI_TH);
        end else begin : g_tx_enc
            always_comb code_now = tx_level_code(int'(count_i), DEPTH, HI_TH);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (access_i) begin
            st_d.pend = 1'b1;
            st_d.left = long_wait_i ? EW'(LONG_EDGES) : EW'(SHORT_EDGES);
        end else if (st_q.pend && ser_edge_i) begin
            st_d.left = st_q.left - EW'(1);
            if (st_q.left == EW'(1)) begin
                st_d.pend = 1'b0;
                st_d.code = code_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{pend: 1'b0, left: '0, code: RST_CODE};
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;

    p_code_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> $past(ser_edge_i));

    p_restart_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(access_i) |-> $stable(code_o));

    p_wait_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left <= EW'(LONG_EDGES));

endmodule

// File: rtl/frame_fifo_port.sv
module frame_fifo_port #(
    parameter int DEPTH       = 19,
    parameter int RX_HI_TH    = 15,
    parameter int TX_HI_TH    = 5,
    parameter int SHORT_EDGES = 2,
    parameter int LONG_EDGES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr_i,
    input  logic       bus_rd_i,
    input  logic       bus_wr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    input  logic       ser_edge_i,
    input  logic [1:0] clk_mode_i,
    input  logic       rx_push_i,
    input  logic [7:0] rx_byte_i,
    input  logic [1:0] rx_tag_i,
    input  logic       tx_pop_i,
    output logic [7:0] tx_byte_o,
    output logic       tx_valid_o,
    output logic       err_o
);
    import frame_fifo_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);
    localparam int RXW = 8 + $bits(frame_tag_e);

    typedef struct packed {
        logic [7:0] last_rd;
        logic       err;
    } port_state_t;

    port_state_t st_d, st_q;

    logic rx_pop, tx_push, long_wait;
    logic [RXW-1:0] rx_head;
    logic [CW-1:0]  rx_cnt, tx_cnt;
    logic rx_full, rx_empty, rx_push_ok, rx_pop_ok;
    logic tx_full, tx_empty, tx_push_ok, tx_pop_ok;
    logic [1:0] rx_code, tx_code;
    logic [7:0] status;

    assign rx_pop    = bus_rd_i && (bus_addr_i == ADDR_RXDATA);
    assign tx_push   = bus_wr_i && (bus_addr_i == ADDR_TXDATA);
    assign long_wait = (clk_mode_i == MODE_FAST_INT);

    byte_queue #(.WIDTH(RXW), .DEPTH(DEPTH)) rx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push_i(rx_push_i), .pop_i(rx_pop),
        .wdata_i({rx_tag_i, rx_byte_i}),
        .head_o(rx_head), .count_o(rx_cnt),
        .full_o(rx_full), .empty_o(rx_empty),
        .push_ok_o(rx_push_ok), .pop_ok_o(rx_pop_ok)
    );

    byte_queue #(.WIDTH(8), .DEPTH(DEPTH)) tx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push_i(tx_push), .pop_i(tx_pop_i),
        .wdata_i(bus_wdata_i),
        .head_o(tx_byte_o), .count_o(tx_cnt),
        .full_o(tx_full), .empty_o(tx_empty),
        .push_ok_o(tx_push_ok), .pop_ok_o(tx_pop_ok)
    );

    level_tracker #(.DEPTH(DEPTH), .HI_TH(RX_HI_TH), .IS_RX(1'b1),
                    .SHORT_EDGES(SHORT_EDGES), .LONG_EDGES(LONG_EDGES)) rx_lvl_i (
        .clk(clk), .rst_n(rst_n),
        .access_i(rx_push_ok || rx_pop_ok),
        .ser_edge_i(ser_edge_i), .long_wait_i(long_wait),
        .count_i(rx_cnt), .code_o(rx_code)
    );

    level_tracker #(.DEPTH(DEPTH), .HI_TH(TX_HI_TH), .IS_RX(1'b0),
                    .SHORT_EDGES(SHORT_EDGES), .LONG_EDGES(LONG_EDGES)) tx_lvl_i (
        .clk(clk), .rst_n(rst_n),
        .access_i(tx_push_ok || tx_pop_ok),
        .ser_edge_i(ser_edge_i), .long_wait_i(long_wait),
        .count_i(tx_cnt), .code_o(tx_code)
    );

    always_comb begin
        status = {(rx_empty ? 2'b00 : rx_head[RXW-1:8]), rx_code, tx_code, 2'b00};
        case (bus_addr_i)
            ADDR_STATUS: bus_rdata_o = status;
            ADDR_RXDATA: bus_rdata_o = rx_empty ? st_q.last_rd : rx_head[7:0];
            default:     bus_rdata_o = 8'h00;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rx_pop_ok) st_d.last_rd = rx_head[7:0];
        if ((rx_push_i && rx_full) || (rx_pop && rx_empty) ||
            (tx_push && tx_full) || (tx_pop_i && tx_empty))
            st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_valid_o = !tx_empty;
    assign err_o      = st_q.err;

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_o) |-> err_o);

    p_low_bits_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == ADDR_STATUS) |-> (bus_rdata_o[1:0] == 2'b00));

    p_empty_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && bus_addr_i == ADDR_STATUS) |-> (bus_rdata_o[7:6] == 2'b00));

    p_underflow_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop_i && !tx_valid_o) |=> err_o);

endmodule

// File: tb/frame_fifo_port_tb_top.sv
module frame_fifo_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ser_edge = 1'b0;
    logic [1:0] clk_mode = 2'b00;
    logic       rx_push = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [1:0] rx_tag = 2'b00;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_valid, err;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    frame_fifo_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr_i(bus_addr), .bus_rd_i(bus_rd), .bus_wr_i(bus_wr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .ser_edge_i(ser_edge), .clk_mode_i(clk_mode),
        .rx_push_i(rx_push), .rx_byte_i(rx_byte), .rx_tag_i(rx_tag),
        .tx_pop_i(tx_pop), .tx_byte_o(tx_byte), .tx_valid_o(tx_valid),
        .err_o(err)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    function automatic logic [1:0] rx_exp(input int n);
        if (n == 0) return 2'b00;
        if (n == 19) return 2'b10;
        if (n >= 15) return 2'b11;
        return 2'b01;
    endfunction

    function automatic logic [1:0] tx_exp(input int n);
        if (n == 19) return 2'b00;
        if (n == 0) return 2'b10;
        if (n >= 5) return 2'b01;
        return 2'b11;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic edges(input int k);
        for (int e = 0; e < k; e++) begin
            ser_edge = 1'b1;
            step();
            ser_edge = 1'b0;
        end
    endtask

    task automatic read_status(output logic [7:0] v);
        bus_addr = 2'd0;
        #1;
        v = bus_rdata;
    endtask

    task automatic push_rx(input logic [7:0] b, input logic [1:0] t);
        rx_push = 1'b1; rx_byte = b; rx_tag = t;
        step();
        rx_push = 1'b0;
    endtask

    task automatic read_rx(output logic [7:0] v);
        bus_addr = 2'd1; bus_rd = 1'b1;
        #1;
        v = bus_rdata;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic write_tx(input logic [7:0] b);
        bus_addr = 2'd2; bus_wr = 1'b1; bus_wdata = b;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic pop_tx;
        tx_pop = 1'b1;
        step();
        tx_pop = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, v;
        logic [1:0] prev, expc;
        int n;

        @(negedge clk);
        do_reset();

        // R1 reset state
        read_status(s);
        chk("R1 status", 32'(s), 32'h08);
        chk("R1 err", 32'(err), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);

        // receive fill, two-edge wait (R5, R8, R11)
        clk_mode = 2'b00;
        prev = 2'b00;
        for (int i = 0; i < 21; i++) begin
            push_rx(pat(i), 2'(i % 4));
            n = (i + 1 > 19) ? 19 : i + 1;
            expc = rx_exp(n);
            edges(1);
            read_status(s);
            chk("R8 rx level before second edge", 32'(s[5:4]), 32'(prev));
            edges(1);
            read_status(s);
            chk("R5 rx level", 32'(s[5:4]), 32'(expc));
            chk("R7 low bits", 32'(s[1:0]), 0);
            chk("R4 head tag while filling", 32'(s[7:6]), 0);
            if (i == 18) chk("R11 no error at exactly full", 32'(err), 0);
            if (i == 19) chk("R11 overflow sets err", 32'(err), 1);
            prev = expc;
        end

        // receive drain, four-edge wait (R2, R4, R9)
        clk_mode = 2'b10;
        for (int j = 0; j < 19; j++) begin
            read_status(s);
            chk("R4 head tag", 32'(s[7:6]), 32'(j % 4));
            read_rx(v);
            chk("R2 rx order and bit position", 32'(v), 32'(pat(j)));
            expc = rx_exp(18 - j);
            edges(3);
            read_status(s);
            chk("R9 rx level before fourth edge", 32'(s[5:4]), 32'(prev));
            edges(1);
            read_status(s);
            chk("R9 rx level after fourth edge", 32'(s[5:4]), 32'(expc));
            prev = expc;
        end
        read_status(s);
        chk("R4 empty tag", 32'(s[7:6]), 0);
        read_rx(v);
        chk("R12 empty read returns last byte", 32'(v), 32'(pat(18)));
        push_rx(8'hA5, 2'b01);
        edges(4);
        read_status(s);
        chk("R12 pointers unmoved, one byte queued", 32'(s[5:4]), 32'b01);
        chk("R4 first tag", 32'(s[7:6]), 32'b01);
        read_rx(v);
        chk("R12 next read gets new byte", 32'(v), 32'hA5);

        // R10 restart, mode 11 uses two edges
        do_reset();
        chk("R1 err cleared by reset", 32'(err), 0);
        read_rx(v);
        chk("R12 empty read after reset returns 0", 32'(v), 0);
        chk("R12 empty pop sets err", 32'(err), 1);
        clk_mode = 2'b11;
        push_rx(8'h11, 2'b00);
        edges(1);
        push_rx(8'h22, 2'b00);
        edges(1);
        read_status(s);
        chk("R10 restart holds level", 32'(s[5:4]), 32'b00);
        edges(1);
        read_status(s);
        chk("R10 level after restarted wait", 32'(s[5:4]), 32'b01);

        // transmit fill, mode 01 two edges (R3, R6, R8, R11)
        do_reset();
        clk_mode = 2'b01;
        prev = 2'b10;
        for (int i = 0; i < 21; i++) begin
            write_tx(pat(i + 50));
            n = (i + 1 > 19) ? 19 : i + 1;
            expc = tx_exp(n);
            edges(1);
            read_status(s);
            chk("R8 tx level before second edge", 32'(s[3:2]), 32'(prev));
            edges(1);
            read_status(s);
            chk("R6 tx level", 32'(s[3:2]), 32'(expc));
            chk("R3 tx head", 32'(tx_byte), 32'(pat(50)));
            if (i == 19) chk("R11 tx overflow sets err", 32'(err), 1);
            prev = expc;
        end

        // transmit drain, four edges (R3, R6, R9)
        clk_mode = 2'b10;
        for (int j = 0; j < 19; j++) begin
            chk("R3 tx order", 32'(tx_byte), 32'(pat(50 + j)));
            chk("R3 tx_valid", 32'(tx_valid), 1);
            pop_tx();
            expc = tx_exp(18 - j);
            edges(3);
            read_status(s);
            chk("R9 tx level before fourth edge", 32'(s[3:2]), 32'(prev));
            edges(1);
            read_status(s);
            chk("R6 tx level after drain step", 32'(s[3:2]), 32'(expc));
            prev = expc;
        end
        chk("R3 tx_valid empty", 32'(tx_valid), 0);
        pop_tx();
        edges(4);
        read_status(s);
        chk("R12 tx empty pop keeps level", 32'(s[3:2]), 32'b10);
        write_tx(8'h3C);
        chk("R12 tx pointers unmoved", 32'(tx_byte), 32'h3C);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule